// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

An eight-bit storage and shift register with four operations: hold, shift toward the least significant bit, shift toward the most significant bit, and synchronous parallel load. Its parallel data path is one shared bus that carries load data into the register and register contents out of it. The shared bus is modelled at the port list as three signals: an input vector, an output vector and one output-enable. Selecting the load operation turns the bus drivers off, so an external agent can present data that is captured on the next rising clock edge.

Two active-low output-control inputs gate the bus drivers in the other three operations. An active-low clear zeroes the register whatever the output state or the selected operation. A parameter chooses whether the clear acts at once (asynchronous) or on the clock edge (synchronous). A serial input at each end and an always-driven serial output from each end bit let several registers be chained into a wider word.

Top module: `univ_shreg`

## Requirements
- R1: With select `sel_i` = 2'b00 (hold), the register keeps its value across clock edges.
- R2: With `sel_i` = 2'b01 (shift right), each rising edge moves bit k+1 into bit k, and `ser_r_i` enters bit 7.
- R3: With `sel_i` = 2'b10 (shift left), each rising edge moves bit k into bit k+1, and `ser_l_i` enters bit 0.
- R4: With `sel_i` = 2'b11 (load), the value on `bus_i` is captured on the rising edge.
- R5: While `sel_i` = 2'b11, `bus_oe_o` is 0 for every value of `oe_ni`.
- R6: Outside load, `bus_oe_o` is 1 only when both bits of `oe_ni` are 0. `bus_o` always presents the current register contents.
- R7: While `clr_ni` is low, the register goes to zero whatever `sel_i` and `oe_ni` are. With `SYNC_CLEAR`=0 (default) this happens without a clock edge. With `SYNC_CLEAR`=1 it happens on the next rising edge.
- R8: `q_lsb_o` equals bit 0 and `q_msb_o` equals bit 7 at all times, whatever the driver state.
- R9: Two instances form a 16-bit register in this arrangement: the upper `q_lsb_o` drives the lower `ser_r_i`, and the lower `q_msb_o` drives the upper `ser_l_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| clr_ni | input | 1 | Active-low clear |
| sel_i | input | 2 | Operation select: 00 hold, 01 shift right, 10 shift left, 11 load |
| oe_ni | input | 2 | Active-low output controls; both must be low to drive |
| ser_r_i | input | 1 | Serial input entering bit 7 on shift right |
| ser_l_i | input | 1 | Serial input entering bit 0 on shift left |
| bus_i | input | WIDTH | Shared bus, inbound data |
| bus_o | output | WIDTH | Shared bus, outbound register contents |
| bus_oe_o | output | 1 | Bus driver enable; 0 means high impedance |
| q_lsb_o | output | 1 | Serial output from bit 0 |
| q_msb_o | output | 1 | Serial output from bit 7 |

## Verification
The operation assertions assume that `clr_ni` is steady across each rising edge they span. They also assume it does not pulse low and return high between two edges, because an asynchronous clear of that kind would break the hold and shift relations without the disable seeing it. The bench changes every input, `clr_ni` included, only at falling edges or in the middle of the high phase. It keeps each clear low through at least one rising edge, and it uses the serial and bus inputs only as the selected operation reads them. A two-instance chain checked against a 16-bit model covers the cascade wiring, and a separate synchronous-clear instance covers the parameter variant.

// File: rtl/univ_shreg_pkg.sv
package univ_shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/univ_shreg_next.sv
module univ_shreg_next
  import univ_shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e            mode_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] nxt_o
);
  always_comb begin
    unique case (mode_i)
      MODE_SHR:  nxt_o = {ser_r_i, q_i[WIDTH-1:1]};
      MODE_SHL:  nxt_o = {q_i[WIDTH-2:0], ser_l_i};
      MODE_LOAD: nxt_o = par_i;
      default:   nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/univ_shreg_bus.sv
module univ_shreg_bus
  import univ_shreg_pkg::*;
#(
  parameter int N_OE = 2
) (
  input  mode_e           mode_i,
  input  logic [N_OE-1:0] oe_ni,
  output logic            drive_o
);
  // load owns the bus for inbound data
  assign drive_o = (oe_ni == '0) && (mode_i != MODE_LOAD);
endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
  import univ_shreg_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int N_OE       = 2,
  parameter bit SYNC_CLEAR = 1'b0
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic [1:0]       sel_i,
  input  logic [N_OE-1:0]  oe_ni,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe_o,
  output logic             q_lsb_o,
  output logic             q_msb_o
);
  localparam int MSB = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;

  assign mode = mode_e'(sel_i);

  univ_shreg_next #(.WIDTH(WIDTH)) u_next (
    .mode_i  (mode),
    .q_i     (q_q),
    .ser_r_i (ser_r_i),
    .ser_l_i (ser_l_i),
    .par_i   (bus_i),
    .nxt_o   (q_d)
  );

  univ_shreg_bus #(.N_OE(N_OE)) u_bus (
    .mode_i  (mode),
    .oe_ni   (oe_ni),
    .drive_o (bus_oe_o)
  );

  generate
    if (SYNC_CLEAR) begin : g_sync_clr
      always_ff @(posedge clk_i) begin
        if (!clr_ni) q_q <= '0;
        else         q_q <= q_d;
      end
    end else begin : g_async_clr
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) q_q <= '0;
        else         q_q <= q_d;
      end
    end
  endgenerate

  assign bus_o   = q_q;
  assign q_lsb_o = q_q[0];
  assign q_msb_o = q_q[MSB];

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (sel_i == 2'b00) |=> $stable(q_q));
  p_shr_r2: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (sel_i == 2'b01) |=> (q_q == {$past(ser_r_i), $past(q_q[MSB:1])}));
  p_shl_r3: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (sel_i == 2'b10) |=> (q_q == {$past(q_q[MSB-1:0]), $past(ser_l_i)}));
  p_load_r4: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (sel_i == 2'b11) |=> (q_q == $past(bus_i)));
  p_hiz_load_r5: assert property (@(posedge clk_i)
    (sel_i == 2'b11) |-> !bus_oe_o);
  p_oe_gate_r6: assert property (@(posedge clk_i)
    (oe_ni != '0) |-> !bus_oe_o);
  p_clear_r7: assert property (@(posedge clk_i)
    !clr_ni |=> (q_q == '0));
endmodule

// File: tb/univ_shreg_tb.sv
`timescale 1ns/1ps
module univ_shreg_tb;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       clr_sync_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [1:0] oe_n = 2'b11;
  logic       ser_r = 1'b0, ser_l = 1'b0;
  logic [7:0] bus_lo = '0, bus_hi = '0;
  logic [7:0] out_lo, out_hi, out_sy;
  logic       oe_lo, oe_hi, oe_sy;
  logic       lsb_lo, msb_lo, lsb_hi, msb_hi, lsb_sy, msb_sy;
  logic [15:0] mdl = '0;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  univ_shreg u_dut (
    .clk_i(clk), .clr_ni(clr_n), .sel_i(sel), .oe_ni(oe_n),
    .ser_r_i(lsb_hi), .ser_l_i(ser_l), .bus_i(bus_lo),
    .bus_o(out_lo), .bus_oe_o(oe_lo), .q_lsb_o(lsb_lo), .q_msb_o(msb_lo));

  univ_shreg u_hi (
    .clk_i(clk), .clr_ni(clr_n), .sel_i(sel), .oe_ni(oe_n),
    .ser_r_i(ser_r), .ser_l_i(msb_lo), .bus_i(bus_hi),
    .bus_o(out_hi), .bus_oe_o(oe_hi), .q_lsb_o(lsb_hi), .q_msb_o(msb_hi));

  univ_shreg #(.SYNC_CLEAR(1'b1)) u_sync (
    .clk_i(clk), .clr_ni(clr_sync_n), .sel_i(sel), .oe_ni(oe_n),
    .ser_r_i(ser_r), .ser_l_i(ser_l), .bus_i(bus_lo),
    .bus_o(out_sy), .bus_oe_o(oe_sy), .q_lsb_o(lsb_sy), .q_msb_o(msb_sy));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, update model, sample 1 ns after rising edge
  task automatic cyc(input logic [1:0] s, input logic sr, input logic sl);
    @(negedge clk);
    sel = s; ser_r = sr; ser_l = sl;
    case (s)
      2'b01:   mdl = {sr, mdl[15:1]};
      2'b10:   mdl = {mdl[14:0], sl};
      2'b11:   mdl = {bus_hi, bus_lo};
      default: mdl = mdl;
    endcase
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R7 reset value", {out_hi, out_lo}, 16'h0000);
    chk("R6 reset drivers off", {15'd0, oe_lo}, 16'd0);
    @(negedge clk);
    clr_n = 1'b1; clr_sync_n = 1'b1;
  endtask

  task automatic t_load_hold;
    @(negedge clk);
    oe_n = 2'b00; bus_lo = 8'hA5; bus_hi = 8'h3C; sel = 2'b11;
    #1;
    chk("R5 load forces hi-z with oe_n=00", {14'd0, oe_hi, oe_lo}, 16'd0);
    cyc(2'b11, 1'b0, 1'b0);
    chk("R4 parallel load", {out_hi, out_lo}, 16'h3CA5);
    bus_lo = 8'h00; bus_hi = 8'hFF;
    cyc(2'b00, 1'b1, 1'b1);
    cyc(2'b00, 1'b1, 1'b1);
    chk("R1 hold ignores bus and serial", {out_hi, out_lo}, mdl);
    chk("R1 hold value", {out_hi, out_lo}, 16'h3CA5);
    chk("R6 drive in hold with oe_n=00", {15'd0, oe_lo}, 16'd1);
  endtask

  task automatic t_oe;
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 4; o++) begin
        @(negedge clk);
        sel = m[1:0]; oe_n = o[1:0];
        #1;
        chk((m == 3) ? "R5 drivers off in load" : "R6 output-control gating",
            {15'd0, oe_lo}, {15'd0, (o == 0) && (m != 3)});
      end
    end
    @(negedge clk);
    sel = 2'b00;
    bus_lo = 8'h12; bus_hi = 8'h34;
    cyc(2'b11, 1'b0, 1'b0);
    cyc(2'b00, 1'b0, 1'b0);
    chk("R6 bus shows contents", {out_hi, out_lo}, 16'h3412);
  endtask

  task automatic t_shr;
    logic [4:0] pat = 5'b01101;
    @(negedge clk);
    oe_n = 2'b11;
    bus_lo = 8'h81; bus_hi = 8'h80;
    cyc(2'b11, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      cyc(2'b01, pat[i], ~pat[i]);
      chk("R2 R9 cascaded shift right", {out_hi, out_lo}, mdl);
      chk("R8 lsb serial out with drivers off", {15'd0, lsb_lo}, {15'd0, mdl[0]});
      chk("R8 upper lsb feeds chain", {15'd0, lsb_hi}, {15'd0, mdl[8]});
    end
    chk("R6 drivers off with oe_n=11", {15'd0, oe_hi}, 16'd0);
  endtask

  task automatic t_shl;
    logic [4:0] pat = 5'b10011;
    bus_lo = 8'h81; bus_hi = 8'h01;
    cyc(2'b11, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      cyc(2'b10, ~pat[i], pat[i]);
      chk("R3 R9 cascaded shift left", {out_hi, out_lo}, mdl);
      chk("R8 msb serial out with drivers off", {15'd0, msb_hi}, {15'd0, mdl[15]});
      chk("R8 lower msb feeds chain", {15'd0, msb_lo}, {15'd0, mdl[7]});
    end
  endtask

  task automatic t_async_clr;
    bus_lo = 8'hF0; bus_hi = 8'h0F;
    cyc(2'b11, 1'b0, 1'b0);
    @(negedge clk);
    oe_n = 2'b00; sel = 2'b11; bus_lo = 8'hFF; bus_hi = 8'hFF;
    @(posedge clk);
    #1.25;
    clr_n = 1'b0;
    #0.5;
    chk("R7 async clear without edge, load mode", {out_hi, out_lo}, 16'h0000);
    chk("R7 clear leaves drivers to mode", {14'd0, oe_hi, oe_lo}, 16'd0);
    @(negedge clk);
    sel = 2'b00;
    #1;
    chk("R7 clear with drivers on", {14'd0, oe_hi, oe_lo}, 16'd3);
    @(posedge clk);
    #1;
    chk("R7 stays zero across edge", {out_hi, out_lo}, 16'h0000);
    @(negedge clk);
    clr_n = 1'b1;
    mdl = '0;
  endtask

  task automatic t_sync_clr;
    bus_lo = 8'hA5;
    cyc(2'b11, 1'b0, 1'b0);
    @(negedge clk);
    sel = 2'b00; clr_sync_n = 1'b0;
    #1;
    chk("R7 sync clear waits for edge", {8'd0, out_sy}, 16'h00A5);
    @(posedge clk);
    #1;
    chk("R7 sync clear on edge", {8'd0, out_sy}, 16'h0000);
    @(negedge clk);
    clr_sync_n = 1'b1;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_load_hold();
    t_oe();
    t_shr();
    t_shl();
    t_async_clr();
    t_sync_clr();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule